// File: doc/BRIEF.md
# FIFO-Level DMA Request Generator

This block watches how full an outgoing sample FIFO is. That FIFO feeds a waveform generator. The block drives the request line of a bus-master DMA engine that refills it. Software picks one of four request policies through a 2-bit mode field, which the block loads on a write strobe. Three of the policies are plain level comparisons: FIFO empty, below half, or below full. The fourth has hysteresis. It begins a fill burst when the level drops below half and keeps requesting until the FIFO is completely full.

The block also reports whether such a burst is in progress. The FIFO storage, the DMA engine and the DAC pacing sit outside the block. The block sees only the occupancy count and the configured depth, which may be 8192 or 16384 samples. The request is formed from the current occupancy without any register in the path, so it falls in the very cycle the FIFO reads full.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `dma_fill_req`

## Requirements
- R1: After reset the stored mode is 0 (request on empty) and burst_active is 0. So with enable high and occupancy 0, dma_req is 1.
- R2: In mode code 0, dma_req is 1 exactly when occupancy equals 0 and the FIFO is not full.
- R3: In mode code 1, dma_req is 1 exactly when occupancy is strictly below depth/2.
- R4: In mode code 2, dma_req is 1 exactly when occupancy is below depth.
- R5: In mode code 3, dma_req is 1 when the FIFO is not full and either occupancy is below depth/2 or burst_active is 1. Once a burst has started, the request therefore stays high as the level climbs back past half.
- R6: burst_active is a registered flag. In mode 3 with enable high, it goes to 1 on the edge after a below-half occupancy is seen. It goes to 0 on the edge after a full occupancy is seen. In any other mode it is 0 from the next edge onward.
- R7: While enable is 0, dma_req is 0 for any occupancy, and burst_active is 0 from the next edge.
- R8: A cycle with mode_wr high loads mode_in, and the new mode applies from the next cycle. It also clears burst_active on the next edge. The clear wins over a set seen in the same cycle.
- R9: Occupancy greater than or equal to depth counts as full. dma_req is 0 in the same cycle full is seen, in every mode.
- R10: Depth is a runtime input up to the parameter DEPTH_MAX. The half and full thresholds follow it, for both 8192 and 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Request generation enable |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_in | input | 2 | Mode value written on mode_wr |
| fifo_level | input | 15 | Current FIFO occupancy in samples |
| fifo_depth | input | 15 | Configured FIFO depth in samples |
| dma_req | output | 1 | DMA request toward the engine |
| burst_active | output | 1 | Mode-3 fill burst in progress |

## Verification
Several events can fall on the same edge as a change to the burst latch in mode 3. A mode write can arrive in the cycle where occupancy is below half, so set and clear compete. Enable can drop in the cycle where the FIFO reaches full. Directed cases place a mode write exactly on a below-half sample. Random stimulus also mixes strobes and enable drops with occupancies clustered around zero, half and full. The bench judges each cycle against a reference model in which the clear takes priority, and checks that the new mode governs the request from the following cycle.

// File: rtl/dma_fill_pkg.sv
`timescale 1ns/1ps
package dma_fill_pkg;
  typedef enum logic [1:0] {
    REQ_ON_EMPTY     = 2'd0,
    REQ_BELOW_HALF   = 2'd1,
    REQ_BELOW_FULL   = 2'd2,
    REQ_HALF_TO_FULL = 2'd3
  } req_mode_e;
endpackage

// File: rtl/fill_compare.sv
`timescale 1ns/1ps
// Level comparators: purely combinational so the full flag has no latency.
module fill_compare #(
  parameter int CNT_W = 15
) (
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] depth,
  output logic             is_empty,
  output logic             below_half,
  output logic             is_full
);
  logic [CNT_W-1:0] half_mark;

  always_comb begin
    half_mark  = depth >> 1;
    is_empty   = (level == '0);
    below_half = (level < half_mark);
    is_full    = (level >= depth);
  end
endmodule

// File: rtl/fill_latch.sv
`timescale 1ns/1ps
// Hysteresis flop for the half-to-full policy.
module fill_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clr_wr,
  input  logic armed_mode,
  input  logic below_half,
  input  logic is_full,
  output logic latched
);
  logic latched_d;

  always_comb begin
    latched_d = latched;
    if (!enable || clr_wr || !armed_mode) latched_d = 1'b0;
    else if (is_full)                     latched_d = 1'b0;
    else if (below_half)                  latched_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latched <= 1'b0;
    else        latched <= latched_d;
  end
endmodule

// File: rtl/req_select.sv
`timescale 1ns/1ps
// Policy multiplexer; full always vetoes the request.
module req_select
  import dma_fill_pkg::*;
(
  input  req_mode_e mode,
  input  logic      enable,
  input  logic      is_empty,
  input  logic      below_half,
  input  logic      is_full,
  input  logic      latched,
  output logic      req
);
  logic cond;

  always_comb begin
    unique case (mode)
      REQ_ON_EMPTY:     cond = is_empty;
      REQ_BELOW_HALF:   cond = below_half;
      REQ_BELOW_FULL:   cond = 1'b1;
      REQ_HALF_TO_FULL: cond = below_half | latched;
      default:          cond = 1'b0;
    endcase
    req = enable & ~is_full & cond;
  end
endmodule

// File: rtl/dma_fill_req.sv
`timescale 1ns/1ps
module dma_fill_req
  import dma_fill_pkg::*;
#(
  parameter int DEPTH_MAX = 16384,
  localparam int CNT_W = $clog2(DEPTH_MAX) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_wr,
  input  logic [1:0]       mode_in,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic [CNT_W-1:0] fifo_depth,
  output logic             dma_req,
  output logic             burst_active
);
  req_mode_e mode_q;
  logic is_empty, below_half, is_full, latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= REQ_ON_EMPTY;
    else if (mode_wr) mode_q <= req_mode_e'(mode_in);
  end

  fill_compare #(.CNT_W(CNT_W)) u_cmp (
    .level(fifo_level), .depth(fifo_depth),
    .is_empty(is_empty), .below_half(below_half), .is_full(is_full)
  );

  fill_latch u_latch (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clr_wr(mode_wr),
    .armed_mode(mode_q == REQ_HALF_TO_FULL),
    .below_half(below_half), .is_full(is_full), .latched(latched)
  );

  req_select u_sel (
    .mode(mode_q), .enable(enable), .is_empty(is_empty),
    .below_half(below_half), .is_full(is_full), .latched(latched),
    .req(dma_req)
  );

  assign burst_active = latched;
endmodule

// File: rtl/dma_fill_req_chk.sv
`timescale 1ns/1ps
module dma_fill_req_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             mode_wr,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] fifo_level,
  input logic [CNT_W-1:0] fifo_depth,
  input logic             dma_req,
  input logic             burst_active
);
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !dma_req);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level >= fifo_depth) |-> !dma_req);
  p_wr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !burst_active);
  p_burst_holds_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && enable && mode_q == 2'd3 && fifo_level < fifo_depth) |-> dma_req);
  p_empty_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode_q == 2'd0 && fifo_level == '0 && fifo_depth != '0) |-> dma_req);
  p_burst_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(fifo_level < (fifo_depth >> 1)));
endmodule

bind dma_fill_req dma_fill_req_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode_wr(mode_wr),
  .mode_q(mode_q), .fifo_level(fifo_level), .fifo_depth(fifo_depth),
  .dma_req(dma_req), .burst_active(burst_active)
);

// File: tb/test_dma_fill_req.sv
`timescale 1ns/1ps
module test_dma_fill_req;
  localparam int CNT_W = 15;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, mode_wr = 1'b0;
  logic [1:0] mode_in = 2'd0;
  logic [CNT_W-1:0] fifo_level = '0, fifo_depth = 15'd16384;
  logic dma_req, burst_active;
  int n_tests = 0, n_fail = 0;
  logic [1:0] m_mode = 2'd0;
  logic m_hyst = 1'b0;

  always #10 clk = ~clk;

  dma_fill_req i_dma_fill_req (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_wr(mode_wr),
    .mode_in(mode_in), .fifo_level(fifo_level), .fifo_depth(fifo_depth),
    .dma_req(dma_req), .burst_active(burst_active)
  );

  function automatic logic exp_req(logic [1:0] md, logic en, int lv, int dp, logic hy);
    logic full, half;
    full = (lv >= dp);
    half = (lv < dp / 2);
    if (!en || full) return 1'b0;
    case (md)
      2'd0: return lv == 0;
      2'd1: return half;
      2'd2: return 1'b1;
      default: return half || hy;
    endcase
  endfunction

  function automatic logic next_hyst(logic [1:0] md, logic en, logic wr, int lv, int dp, logic hy);
    if (!en || wr || md != 2'd3) return 1'b0;
    if (lv >= dp) return 1'b0;
    if (lv < dp / 2) return 1'b1;
    return hy;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (mode %0d level %0d depth %0d)",
               tag, act, exp, m_mode, fifo_level, fifo_depth);
    end
  endtask

  function automatic string req_tag(logic [1:0] md, logic en, int lv, int dp);
    if (!en) return "R7";
    if (lv >= dp) return "R9";
    case (md)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // drive on negedge, check mid-low-phase, advance model at posedge
  task automatic step(logic en, logic wr, logic [1:0] mi, int lv, string tag_over = "");
    @(negedge clk);
    enable = en; mode_wr = wr; mode_in = mi; fifo_level = CNT_W'(lv);
    #5;
    check(tag_over != "" ? tag_over : req_tag(m_mode, en, lv, int'(fifo_depth)),
          dma_req, exp_req(m_mode, en, lv, int'(fifo_depth), m_hyst));
    check(tag_over != "" ? tag_over : "R6", burst_active, m_hyst);
    @(posedge clk);
    m_hyst = next_hyst(m_mode, en, wr, lv, int'(fifo_depth), m_hyst);
    if (wr) m_mode = mi;
  endtask

  task automatic set_mode(logic [1:0] mi);
    step(1'b1, 1'b1, mi, int'(fifo_depth), "R8");
  endtask

  function automatic int pick_level(int dp);
    case ($urandom_range(0, 5))
      0: return 0;
      1: return dp / 2 - 1 + int'($urandom_range(0, 2));
      2: return dp - 1 + int'($urandom_range(0, 1));
      3: return int'($urandom_range(0, 3));
      default: return int'($urandom_range(0, dp));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #5;
    check("R1", burst_active, 1'b0);
    rst_n = 1'b1;
    // R1: default mode is request-on-empty
    step(1'b1, 1'b0, 2'd0, 0, "R1");
    step(1'b1, 1'b0, 2'd0, 5, "R2");
    // R5/R6 directed hysteresis sweep
    set_mode(2'd3);
    step(1'b1, 1'b0, 2'd0, 9000);
    step(1'b1, 1'b0, 2'd0, 8191, "R5");
    step(1'b1, 1'b0, 2'd0, 8192, "R5");
    step(1'b1, 1'b0, 2'd0, 12000, "R5");
    step(1'b1, 1'b0, 2'd0, 16383, "R5");
    step(1'b1, 1'b0, 2'd0, 16384, "R9");
    step(1'b1, 1'b0, 2'd0, 12000, "R6");
    // R8: write coincides with below-half sample
    step(1'b1, 1'b0, 2'd0, 100, "R5");
    step(1'b1, 1'b1, 2'd3, 100, "R8");
    step(1'b1, 1'b0, 2'd0, 9000, "R8");
    // R7: enable drops while bursting
    step(1'b1, 1'b0, 2'd0, 10, "R5");
    step(1'b0, 1'b0, 2'd0, 10, "R7");
    step(1'b1, 1'b0, 2'd0, 9000, "R7");
    // R10: 8K depth
    fifo_depth = 15'd8192;
    set_mode(2'd1);
    step(1'b1, 1'b0, 2'd0, 4095, "R10");
    step(1'b1, 1'b0, 2'd0, 4096, "R10");
    set_mode(2'd2);
    step(1'b1, 1'b0, 2'd0, 8191, "R10");
    step(1'b1, 1'b0, 2'd0, 8192, "R10");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if (i % 1000 == 0) fifo_depth = (i % 2000 == 0) ? 15'd16384 : 15'd8192;
      step($urandom_range(0, 15) != 0, $urandom_range(0, 19) == 0,
           2'($urandom_range(0, 3)), pick_level(int'(fifo_depth)));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule